// File: doc/BRIEF.md
# Character-Cell Raster Fetch Sequencer

This block paces the scan lines of a character-cell LCD raster and issues the memory fetches that feed a text and graphics display pipeline. Each scan line is split into a fixed slot budget. The first slots fetch character and attribute words into a row buffer. The next slots fetch font or pixel words into a line buffer. The remaining slots form horizontal blanking. Character words are fetched only on the top scan line of each character row, and the later lines of that row reuse the row buffer. A per-frame option blanks the top line's pixels and skips its line fetch, which reserves one empty line of vertical space in every cell.

The block counts character rows, scan lines per row and bottom adjust lines. It advances the character address by a row stride that includes a programmable skip count, and it forms font addresses from a 256-word page base. It also drives the underline scan match, horizontal and vertical blanking, a side-blanking flag, a dot-doubling enable and the decoded cell width. One side-blanked graphics mode places the adjust lines at the top of the frame as well as at the bottom. All configuration inputs are sampled in a single load cycle that starts each frame. Changes made during a frame therefore wait for the next one.

Top module: `rf_fetch_seq`

## Requirements
- R1: During an active line whose scan index is 0, `row_req_o` is high for slots 0 to C-1, where C is the column count and slot 0 is the first cycle of the line. `row_addr_o` equals the current character base plus the slot number. `row_req_o` is low on every other line and slot.
- R2: On every active line, `line_req_o` is high for slots C to 2C-1, and `line_addr_o` takes column index k = slot-C. In text mode (`gfx_i`=0) the address is ((font page + scan index) × 256) + k. In graphics mode it is (active line number × stride) + k, where stride = C + skip count. Both addresses are 16 bits wide and wrap.
- R3: With `no_first_pix_i`=1, `pix_blank_o` is high for the whole of each active line with scan index 0, and `line_req_o` stays low on that line. The row fetch of R1 is unchanged.
- R4: The character base is 0 on the first active line of a frame. It grows by C + skip count at the end of each character row.
- R5: A frame consists of rows×(max_scan+1) active lines, followed by adj bottom lines with `vblank_o` high and no requests. Then comes one load cycle with `sof_o`, `vblank_o` and `hblank_o` high. When adj is 0 the load cycle follows the last active line directly.
- R6: When `gfx_i`=1 and `side_mode_i`=1, adj blank lines also come before the first active line, and `edge_blank_o` is 1. In text mode `side_mode_i` adds no top lines and `edge_blank_o` is 0.
- R7: `cell_dots_o` decodes `cell_code_i` as follows: 00 gives 8, 01 gives 16, and 10 or 11 give 10.
- R8: `ul_hit_o` is high for a whole active line only when the mode is text, `ul_line_i` ≤ `max_scan_i`, and the scan index equals `ul_line_i`.
- R9: `dot_dbl_o` follows the `dbl_i` value sampled for the current frame.
- R10: Each line lasts 2C+HBL_CYC cycles, and `hblank_o` is high in slots 2C and above.
- R11: Configuration inputs are sampled only in the load cycle. A change made during a frame has no effect until the next frame.
- R12: While `rst_n` is low, `sof_o` and `vblank_o` are high and both request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| cols_i | input | 7 | characters per line (C) |
| rows_i | input | 8 | character rows per frame |
| max_scan_i | input | 5 | scan lines per row minus one |
| adj_i | input | 6 | adjust blank line count |
| skip_i | input | 6 | extra words skipped per row |
| font_page_i | input | 5 | font table base, 256-word page |
| ul_line_i | input | 5 | underline scan index |
| cell_code_i | input | 2 | cell width code |
| gfx_i | input | 1 | 1 = graphics mode |
| side_mode_i | input | 1 | side-blanked graphics mode |
| no_first_pix_i | input | 1 | blank the top line of each row |
| dbl_i | input | 1 | dot doubling enable |
| row_req_o | output | 1 | row buffer fetch request |
| row_addr_o | output | 16 | character word address |
| line_req_o | output | 1 | line buffer fetch request |
| line_addr_o | output | 16 | font or pixel word address |
| pix_blank_o | output | 1 | current line pixels forced blank |
| ul_hit_o | output | 1 | underline scan match |
| hblank_o | output | 1 | horizontal blanking |
| vblank_o | output | 1 | vertical blanking |
| sof_o | output | 1 | frame load cycle |
| edge_blank_o | output | 1 | blank 80 dots on each side |
| dot_dbl_o | output | 1 | send each dot twice |
| cell_dots_o | output | 5 | decoded cell width in dots |

## Verification
The riskiest overlap is a configuration change that falls in the same cycle as the frame load. The other dangerous case is a change made in the middle of a frame while the old frame is still being fetched. The bench drives new values exactly at a load cycle, and again a few cycles into a frame. A per-cycle frame model is checked against every request, address and blanking output. It uses the old values for the rest of that frame and the new ones from the next load onward. With the adjust count set to zero, the end of the last character row also falls on the frame restart, and the bench checks that the row advance and the reload of the base line up.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int COLS_W  = 7;
    localparam int ROWS_W  = 8;
    localparam int SCAN_W  = 5;
    localparam int ADJ_W   = 6;
    localparam int OFF_W   = 6;
    localparam int FONT_W  = 5;
    localparam int ADDR_W  = 16;
    localparam int DOTS_W  = 5;
    localparam int PAGE_SH = 8;
    localparam int SLOT_W  = COLS_W + 2;

    typedef enum logic [1:0] {
        PH_LOAD,
        PH_TOP,
        PH_ACT,
        PH_BOT
    } vphase_e;

    typedef struct packed {
        logic [COLS_W-1:0] cols;
        logic [ROWS_W-1:0] rows;
        logic [SCAN_W-1:0] max_scan;
        logic [ADJ_W-1:0]  adj;
        logic [OFF_W-1:0]  skip;
        logic [FONT_W-1:0] font_page;
        logic [SCAN_W-1:0] ul_line;
        logic [1:0]        cell_code;
        logic              gfx;
        logic              side_mode;
        logic              no_first_pix;
        logic              dbl;
    } cfg_t;
endpackage

// File: rtl/rf_cfg_shadow.sv
module rf_cfg_shadow
    import rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  cfg_t              cfg_in,
    output cfg_t              cfg_q,
    output logic [DOTS_W-1:0] cell_dots,
    output logic              edge_blank,
    output logic              dot_dbl
);
    typedef struct packed {
        cfg_t cfg;
    } shadow_t;

    shadow_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cfg = cfg_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q = st_q.cfg;

    always_comb begin
        unique case (st_q.cfg.cell_code)
            2'b00:   cell_dots = DOTS_W'(8);
            2'b01:   cell_dots = DOTS_W'(16);
            default: cell_dots = DOTS_W'(10);
        endcase
    end

    assign edge_blank = st_q.cfg.gfx & st_q.cfg.side_mode;
    assign dot_dbl    = st_q.cfg.dbl;
endmodule

// File: rtl/rf_timing.sv
module rf_timing
    import rf_pkg::*;
#(
    parameter int HBL_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COLS_W-1:0] cols_q,
    input  logic [ROWS_W-1:0] rows_q,
    input  logic [SCAN_W-1:0] max_scan_q,
    input  logic [ADJ_W-1:0]  adj_q,
    input  logic [ROWS_W-1:0] rows_nx,
    input  logic [ADJ_W-1:0]  adj_nx,
    input  logic              top_nx,
    output vphase_e           phase,
    output logic [SLOT_W-1:0] slot,
    output logic [SCAN_W-1:0] scan,
    output logic              line_end,
    output logic              row_end
);
    typedef struct packed {
        vphase_e           phase;
        logic [SLOT_W-1:0] slot;
        logic [SCAN_W-1:0] scan;
        logic [ROWS_W-1:0] row;
        logic [ADJ_W-1:0]  adj_cnt;
    } tim_t;

    tim_t st_d, st_q;

    logic [SLOT_W-1:0] line_len;
    logic              adj_last;

    assign line_len = {1'b0, cols_q, 1'b0} + SLOT_W'(HBL_CYC);
    assign line_end = (st_q.phase != PH_LOAD) && (st_q.slot == line_len - SLOT_W'(1));
    assign adj_last = (st_q.adj_cnt == adj_q - ADJ_W'(1));

    always_comb begin
        st_d    = st_q;
        row_end = 1'b0;
        if (st_q.phase == PH_LOAD) begin
            st_d.slot    = '0;
            st_d.scan    = '0;
            st_d.row     = '0;
            st_d.adj_cnt = '0;
            if (top_nx && (adj_nx != '0)) begin
                st_d.phase = PH_TOP;
            end else if (rows_nx != '0) begin
                st_d.phase = PH_ACT;
            end else if (adj_nx != '0) begin
                st_d.phase = PH_BOT;
            end else begin
                st_d.phase = PH_LOAD;
            end
        end else if (!line_end) begin
            st_d.slot = st_q.slot + SLOT_W'(1);
        end else begin
            st_d.slot = '0;
            unique case (st_q.phase)
                PH_TOP: begin
                    if (adj_last) begin
                        st_d.adj_cnt = '0;
                        st_d.phase   = (rows_q != '0) ? PH_ACT : PH_BOT;
                    end else begin
                        st_d.adj_cnt = st_q.adj_cnt + ADJ_W'(1);
                    end
                end
                PH_ACT: begin
                    if (st_q.scan == max_scan_q) begin
                        st_d.scan = '0;
                        row_end   = 1'b1;
                        if (st_q.row == rows_q - ROWS_W'(1)) begin
                            st_d.row   = '0;
                            st_d.phase = (adj_q != '0) ? PH_BOT : PH_LOAD;
                        end else begin
                            st_d.row = st_q.row + ROWS_W'(1);
                        end
                    end else begin
                        st_d.scan = st_q.scan + SCAN_W'(1);
                    end
                end
                default: begin
                    if (adj_last) begin
                        st_d.adj_cnt = '0;
                        st_d.phase   = PH_LOAD;
                    end else begin
                        st_d.adj_cnt = st_q.adj_cnt + ADJ_W'(1);
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_LOAD, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.phase;
    assign slot  = st_q.slot;
    assign scan  = st_q.scan;
endmodule

// File: rtl/rf_addr.sv
module rf_addr
    import rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  vphase_e           phase,
    input  logic [SLOT_W-1:0] slot,
    input  logic [SCAN_W-1:0] scan,
    input  logic              line_end,
    input  logic              row_end,
    input  logic [COLS_W-1:0] cols_q,
    input  logic [OFF_W-1:0]  skip_q,
    input  logic [FONT_W-1:0] font_q,
    input  logic [SCAN_W-1:0] ul_q,
    input  logic [SCAN_W-1:0] max_scan_q,
    input  logic              gfx_q,
    input  logic              nfp_q,
    output logic              row_req,
    output logic [ADDR_W-1:0] row_addr,
    output logic              line_req,
    output logic [ADDR_W-1:0] line_addr,
    output logic              pix_blank,
    output logic              ul_hit,
    output logic              hblank,
    output logic              vblank,
    output logic              sof
);
    typedef struct packed {
        logic [ADDR_W-1:0] char_base;
        logic [ADDR_W-1:0] gfx_base;
    } base_t;

    base_t st_d, st_q;

    logic [ADDR_W-1:0] stride;
    logic [SLOT_W-1:0] cols_ext;
    logic [SLOT_W-1:0] col_pix;
    logic              act;
    logic              first;
    logic              row_win;
    logic              pix_win;
    logic [ADDR_W-1:0] font_line;

    assign stride   = ADDR_W'(cols_q) + ADDR_W'(skip_q);
    assign cols_ext = SLOT_W'(cols_q);
    assign col_pix  = slot - cols_ext;
    assign act      = (phase == PH_ACT);
    assign first    = (scan == '0);
    assign row_win  = (slot < cols_ext);
    assign pix_win  = !row_win && (slot < {1'b0, cols_q, 1'b0});

    always_comb begin
        st_d = st_q;
        if (phase == PH_LOAD) begin
            st_d.char_base = '0;
            st_d.gfx_base  = '0;
        end else if (act && line_end) begin
            st_d.gfx_base = st_q.gfx_base + stride;
            if (row_end) begin
                st_d.char_base = st_q.char_base + stride;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign font_line = (ADDR_W'(font_q) + ADDR_W'(scan)) << PAGE_SH;

    assign row_req   = act && first && row_win;
    assign row_addr  = st_q.char_base + ADDR_W'(slot[COLS_W-1:0]);
    assign pix_blank = act && first && nfp_q;
    assign line_req  = act && pix_win && !pix_blank;
    assign line_addr = gfx_q ? (st_q.gfx_base + ADDR_W'(col_pix[COLS_W-1:0]))
                             : (font_line + ADDR_W'(col_pix[COLS_W-1:0]));
    assign ul_hit    = act && !gfx_q && (ul_q <= max_scan_q) && (scan == ul_q);
    assign hblank    = (phase == PH_LOAD) || !(row_win || pix_win);
    assign vblank    = !act;
    assign sof       = (phase == PH_LOAD);
endmodule

// File: rtl/rf_fetch_seq.sv
module rf_fetch_seq
    import rf_pkg::*;
#(
    parameter int HBL_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COLS_W-1:0] cols_i,
    input  logic [ROWS_W-1:0] rows_i,
    input  logic [SCAN_W-1:0] max_scan_i,
    input  logic [ADJ_W-1:0]  adj_i,
    input  logic [OFF_W-1:0]  skip_i,
    input  logic [FONT_W-1:0] font_page_i,
    input  logic [SCAN_W-1:0] ul_line_i,
    input  logic [1:0]        cell_code_i,
    input  logic              gfx_i,
    input  logic              side_mode_i,
    input  logic              no_first_pix_i,
    input  logic              dbl_i,
    output logic              row_req_o,
    output logic [ADDR_W-1:0] row_addr_o,
    output logic              line_req_o,
    output logic [ADDR_W-1:0] line_addr_o,
    output logic              pix_blank_o,
    output logic              ul_hit_o,
    output logic              hblank_o,
    output logic              vblank_o,
    output logic              sof_o,
    output logic              edge_blank_o,
    output logic              dot_dbl_o,
    output logic [DOTS_W-1:0] cell_dots_o
);
    cfg_t              cfg_in;
    cfg_t              cfg_q;
    vphase_e           phase;
    logic [SLOT_W-1:0] slot;
    logic [SCAN_W-1:0] scan;
    logic              line_end;
    logic              row_end;

    assign cfg_in = '{cols: cols_i, rows: rows_i, max_scan: max_scan_i, adj: adj_i,
                      skip: skip_i, font_page: font_page_i, ul_line: ul_line_i,
                      cell_code: cell_code_i, gfx: gfx_i, side_mode: side_mode_i,
                      no_first_pix: no_first_pix_i, dbl: dbl_i};

    rf_cfg_shadow u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (phase == PH_LOAD),
        .cfg_in     (cfg_in),
        .cfg_q      (cfg_q),
        .cell_dots  (cell_dots_o),
        .edge_blank (edge_blank_o),
        .dot_dbl    (dot_dbl_o)
    );

    rf_timing #(.HBL_CYC(HBL_CYC)) u_timing (
        .clk        (clk),
        .rst_n      (rst_n),
        .cols_q     (cfg_q.cols),
        .rows_q     (cfg_q.rows),
        .max_scan_q (cfg_q.max_scan),
        .adj_q      (cfg_q.adj),
        .rows_nx    (rows_i),
        .adj_nx     (adj_i),
        .top_nx     (gfx_i & side_mode_i),
        .phase      (phase),
        .slot       (slot),
        .scan       (scan),
        .line_end   (line_end),
        .row_end    (row_end)
    );

    rf_addr u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .slot       (slot),
        .scan       (scan),
        .line_end   (line_end),
        .row_end    (row_end),
        .cols_q     (cfg_q.cols),
        .skip_q     (cfg_q.skip),
        .font_q     (cfg_q.font_page),
        .ul_q       (cfg_q.ul_line),
        .max_scan_q (cfg_q.max_scan),
        .gfx_q      (cfg_q.gfx),
        .nfp_q      (cfg_q.no_first_pix),
        .row_req    (row_req_o),
        .row_addr   (row_addr_o),
        .line_req   (line_req_o),
        .line_addr  (line_addr_o),
        .pix_blank  (pix_blank_o),
        .ul_hit     (ul_hit_o),
        .hblank     (hblank_o),
        .vblank     (vblank_o),
        .sof        (sof_o)
    );
endmodule

// File: rtl/rf_fetch_seq_chk.sv
module rf_fetch_seq_chk
    import rf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              row_req_o,
    input logic [ADDR_W-1:0] row_addr_o,
    input logic              line_req_o,
    input logic              pix_blank_o,
    input logic              ul_hit_o,
    input logic              hblank_o,
    input logic              vblank_o,
    input logic              sof_o,
    input logic              edge_blank_o,
    input logic              dot_dbl_o,
    input logic [DOTS_W-1:0] cell_dots_o
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    assert_one_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(row_req_o && line_req_o));

    assert_row_in_view_R1: assert property (@(posedge clk) disable iff (!rst_n)
        row_req_o |-> (!vblank_o && !hblank_o));

    assert_row_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && row_req_o && $past(row_req_o)) |-> (row_addr_o == $past(row_addr_o) + 16'd1));

    assert_blank_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_blank_o |-> !line_req_o);

    assert_ul_view_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ul_hit_o |-> !vblank_o);

    assert_sof_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sof_o |-> (vblank_o && hblank_o && !row_req_o && !line_req_o));

    assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(sof_o)) |-> ($stable(edge_blank_o) && $stable(dot_dbl_o) && $stable(cell_dots_o)));

    assert_cell_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_dots_o == 5'd8) || (cell_dots_o == 5'd10) || (cell_dots_o == 5'd16));
endmodule

bind rf_fetch_seq rf_fetch_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .row_req_o    (row_req_o),
    .row_addr_o   (row_addr_o),
    .line_req_o   (line_req_o),
    .pix_blank_o  (pix_blank_o),
    .ul_hit_o     (ul_hit_o),
    .hblank_o     (hblank_o),
    .vblank_o     (vblank_o),
    .sof_o        (sof_o),
    .edge_blank_o (edge_blank_o),
    .dot_dbl_o    (dot_dbl_o),
    .cell_dots_o  (cell_dots_o)
);

// File: tb/rf_fetch_seq_tb.sv
module rf_fetch_seq_tb;
    localparam int HBL = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  cols_i = '0;
    logic [7:0]  rows_i = '0;
    logic [4:0]  max_scan_i = '0;
    logic [5:0]  adj_i = '0;
    logic [5:0]  skip_i = '0;
    logic [4:0]  font_page_i = '0;
    logic [4:0]  ul_line_i = '0;
    logic [1:0]  cell_code_i = '0;
    logic        gfx_i = 1'b0;
    logic        side_mode_i = 1'b0;
    logic        no_first_pix_i = 1'b0;
    logic        dbl_i = 1'b0;
    logic        row_req_o, line_req_o, pix_blank_o, ul_hit_o;
    logic        hblank_o, vblank_o, sof_o, edge_blank_o, dot_dbl_o;
    logic [15:0] row_addr_o, line_addr_o;
    logic [4:0]  cell_dots_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    rf_fetch_seq #(.HBL_CYC(HBL)) u_dut (
        .clk(clk), .rst_n(rst_n), .cols_i(cols_i), .rows_i(rows_i),
        .max_scan_i(max_scan_i), .adj_i(adj_i), .skip_i(skip_i),
        .font_page_i(font_page_i), .ul_line_i(ul_line_i), .cell_code_i(cell_code_i),
        .gfx_i(gfx_i), .side_mode_i(side_mode_i), .no_first_pix_i(no_first_pix_i),
        .dbl_i(dbl_i), .row_req_o(row_req_o), .row_addr_o(row_addr_o),
        .line_req_o(line_req_o), .line_addr_o(line_addr_o), .pix_blank_o(pix_blank_o),
        .ul_hit_o(ul_hit_o), .hblank_o(hblank_o), .vblank_o(vblank_o), .sof_o(sof_o),
        .edge_blank_o(edge_blank_o), .dot_dbl_o(dot_dbl_o), .cell_dots_o(cell_dots_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s at %0t: actual %0d expected %0d", req, what, $time, act, exp);
        end
    endtask

    task automatic set_cfg(input int c, input int r, input int m, input int a, input int sk,
                           input int f, input int u, input int cc, input bit g,
                           input bit sd, input bit nf, input bit db);
        cols_i = 7'(c); rows_i = 8'(r); max_scan_i = 5'(m); adj_i = 6'(a);
        skip_i = 6'(sk); font_page_i = 5'(f); ul_line_i = 5'(u); cell_code_i = 2'(cc);
        gfx_i = g; side_mode_i = sd; no_first_pix_i = nf; dbl_i = db;
    endtask

    task automatic check_load(input string tag);
        chk("R5", {tag, " sof"}, int'(sof_o), 1);
        chk("R5", {tag, " vblank at load"}, int'(vblank_o), 1);
        chk("R5", {tag, " hblank at load"}, int'(hblank_o), 1);
        chk("R5", {tag, " no fetch at load"}, int'(row_req_o | line_req_o), 0);
    endtask

    // Called at a negedge where sof_o is high; walks one frame and ends on the next load cycle.
    task automatic check_frame(input int chg_at);
        int k_c = int'(cols_i), k_r = int'(rows_i), k_m = int'(max_scan_i);
        int k_a = int'(adj_i), k_s = int'(skip_i), k_f = int'(font_page_i);
        int k_u = int'(ul_line_i), k_cc = int'(cell_code_i);
        bit k_g = gfx_i, k_sd = side_mode_i, k_nf = no_first_pix_i, k_db = dbl_i;
        int stride = k_c + k_s;
        int top = (k_g && k_sd) ? k_a : 0;
        int act_lines = k_r * (k_m + 1);
        int cyc = 0;
        check_load("frame start");
        for (int ph = 0; ph < 3; ph++) begin
            int nl = (ph == 0) ? top : ((ph == 1) ? act_lines : k_a);
            for (int ln = 0; ln < nl; ln++) begin
                int scan = (ph == 1) ? (ln % (k_m + 1)) : 0;
                int row  = (ph == 1) ? (ln / (k_m + 1)) : 0;
                for (int s = 0; s < 2 * k_c + HBL; s++) begin
                    bit act, e_rr, e_lr, e_pb, e_ul;
                    int e_ra, e_la;
                    @(negedge clk);
                    cyc++;
                    if (cyc == chg_at) begin
                        set_cfg(3, 1, 1, 1, 1, 9, 0, 1, 1'b0, 1'b0, ~k_nf, ~k_db);
                    end
                    act  = (ph == 1);
                    e_rr = act && (scan == 0) && (s < k_c);
                    e_pb = act && (scan == 0) && k_nf;
                    e_lr = act && (s >= k_c) && (s < 2 * k_c) && !e_pb;
                    e_ul = act && !k_g && (k_u <= k_m) && (scan == k_u);
                    e_ra = (row * stride + s) & 16'hFFFF;
                    e_la = k_g ? ((ln * stride + s - k_c) & 16'hFFFF)
                               : ((((k_f + scan) << 8) + s - k_c) & 16'hFFFF);
                    if (cyc == 1) begin
                        int e_dots = (k_cc == 0) ? 8 : ((k_cc == 1) ? 16 : 10);
                        chk("R7", "cell dots", int'(cell_dots_o), e_dots);
                        chk("R6", "edge blank", int'(edge_blank_o), int'(k_g && k_sd));
                        chk("R9", "dot double", int'(dot_dbl_o), int'(k_db));
                    end
                    chk("R1", "row_req", int'(row_req_o), int'(e_rr));
                    if (e_rr) chk("R4", "row_addr", int'(row_addr_o), e_ra);
                    chk("R3", "line_req", int'(line_req_o), int'(e_lr));
                    if (e_lr) chk("R2", "line_addr", int'(line_addr_o), e_la);
                    chk("R3", "pix_blank", int'(pix_blank_o), int'(e_pb));
                    chk("R8", "ul_hit", int'(ul_hit_o), int'(e_ul));
                    chk("R10", "hblank", int'(hblank_o), int'(s >= 2 * k_c));
                    chk("R6", "vblank", int'(vblank_o), int'(!act));
                    chk("R5", "sof inside frame", int'(sof_o), 0);
                end
            end
        end
        @(negedge clk);
        check_load("frame end");
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        set_cfg(4, 2, 2, 2, 3, 5, 1, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        chk("R12", "sof in reset", int'(sof_o), 1);
        chk("R12", "vblank in reset", int'(vblank_o), 1);
        chk("R12", "no fetch in reset", int'(row_req_o | line_req_o), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_text_basic;
        set_cfg(4, 2, 2, 2, 3, 5, 1, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        check_frame(0);
        check_frame(0);
    endtask

    task automatic t_first_line_blank;
        set_cfg(5, 3, 1, 1, 2, 7, 1, 1, 1'b0, 1'b0, 1'b1, 1'b1);
        check_frame(0);
    endtask

    task automatic t_side_graphics;
        set_cfg(5, 3, 0, 3, 1, 2, 0, 1, 1'b1, 1'b1, 1'b0, 1'b1);
        check_frame(0);
    endtask

    task automatic t_side_text;
        set_cfg(4, 2, 1, 2, 0, 3, 0, 3, 1'b0, 1'b1, 1'b0, 1'b0);
        check_frame(0);
    endtask

    task automatic t_underline_limits;
        set_cfg(3, 2, 2, 1, 1, 4, 4, 2, 1'b0, 1'b0, 1'b0, 1'b0);
        check_frame(0);
        set_cfg(3, 2, 2, 1, 1, 4, 2, 3, 1'b0, 1'b0, 1'b0, 1'b0);
        check_frame(0);
    endtask

    task automatic t_no_adjust;
        set_cfg(4, 2, 1, 0, 5, 1, 1, 0, 1'b1, 1'b0, 1'b0, 1'b0);
        check_frame(0);
    endtask

    task automatic t_midframe_change;
        set_cfg(4, 2, 2, 2, 3, 5, 1, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        check_frame(5);
        check_frame(0);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_text_basic();
        t_first_line_blank();
        t_side_graphics();
        t_side_text();
        t_underline_limits();
        t_no_adjust();
        t_midframe_change();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule